// File: doc/BRIEF.md
# Status LED Driver with Remote Override

This block drives the status and front-panel indicator LEDs of a board-level system controller that runs from a 24.576 MHz clock. It has six remotely controllable LED outputs. While a remote GPIO link reports itself active, each of these outputs copies one bit of the remote GPIO word. Two of those bits are inverted on the way out. When the link is not active, each output falls back to a local behaviour. Depending on the LED, that behaviour is a slow blink while system power is off, a steady level, a reset-button indication merged with a repeating burst pattern, or a signal forwarded from another input. A seventh LED on the expansion header shows whether the programmable device has been configured, and the remote link cannot override it.

Two generators inside the block produce the blink sources. A shared divider makes a 50% square wave of about 0.7 Hz and a slower prescaler tick. A three-state machine runs on that tick and makes the burst pattern for the red LED. Its states are GAP, PULSE_ON and PULSE_OFF. The transitions are as follows. GAP goes to PULSE_ON after GAP_TICKS ticks. PULSE_ON goes to PULSE_OFF after ON_TICKS ticks. PULSE_OFF goes back to PULSE_ON after OFF_TICKS ticks while pulses of the burst remain. PULSE_OFF goes to GAP after the last pulse. A synchronous reset puts the divider counters at zero and the machine in GAP, so every blink phase starts from a known point.

Top module: `status_led_drv`

## Requirements
- R1: The slow blink is 0 for the first SLOW_DIV clocks after reset is released and then inverts every SLOW_DIV clocks. With the default SLOW_DIV of 17,554,286, this gives about 0.7 Hz at 24.576 MHz with a 50% duty cycle.
- R2: When remote_active is 1, led_green equals remote_bits[5]. Otherwise led_green equals the slow blink while power_on is 0, and is 1 while power_on is 1.
- R3: When remote_active is 1, led_red equals remote_bits[6]. Otherwise led_red is 1 when rst_btn_n is 0 (button pressed) or when the burst pattern is lit.
- R4: When remote_active is 1, pwr_led_n equals remote_bits[7] and disk_led_n equals remote_bits[9]. Otherwise both are 0.
- R5: When remote_active is 1, pwr_led_p equals the inverse of remote_bits[8]. Otherwise pwr_led_p equals the slow blink while power_on is 0, and equals mio_fwd while power_on is 1.
- R6: When remote_active is 1, disk_led_p equals the inverse of remote_bits[10]. Otherwise disk_led_p equals fpga_io_fwd.
- R7: hdr_led is 1 while cfg_done is 0 (device not configured) and 0 while cfg_done is 1. remote_active and remote_bits have no effect on it.
- R8: The burst pattern advances once every TICK_DIV clocks. After reset it is dark for GAP_TICKS ticks. It then gives PULSES pulses, each lit for ON_TICKS ticks and then dark for OFF_TICKS ticks. The whole sequence then repeats.
- R9: A synchronous reset held for at least one clock restarts both generators: the slow blink at 0 with its count at zero, and the burst pattern at the start of its dark gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (24.576 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| remote_active | input | 1 | Remote GPIO link is active; enables the overrides |
| remote_bits | input | RB_W (16) | Remote GPIO word driven by the FPGA |
| power_on | input | 1 | System power state (1 = on) |
| rst_btn_n | input | 1 | Reset button, active low |
| mio_fwd | input | 1 | Forwarded processor I/O for the power LED |
| fpga_io_fwd | input | 1 | Forwarded FPGA I/O for the disk LED |
| cfg_done | input | 1 | Device configuration done (1 = programmed) |
| led_green | output | 1 | Green status LED |
| led_red | output | 1 | Red status LED |
| pwr_led_n | output | 1 | Power LED negative leg |
| pwr_led_p | output | 1 | Power LED positive leg |
| disk_led_n | output | 1 | Disk LED negative leg |
| disk_led_p | output | 1 | Disk LED positive leg |
| hdr_led | output | 1 | Expansion-header LED |

## Verification
Random cycles mix remote_active, the remote word, power_on, the button and the forwarded inputs. They show whether each output picks its override or its fallback, and that only the two inverted bits are flipped. Runs of several hundred cycles with the link inactive and power off expose the slow blink and the burst pattern on led_green, pwr_led_p and led_red. A bench model counts clocks from reset and predicts the exact edge of every phase change, so an off-by-one in a divider or in the state machine shows up. Directed all-zero and all-one remote words show whether a bit mapping is swapped. A mid-run reset checks that both generators return to their starting phase.

// File: rtl/sled_pkg.sv
package sled_pkg;

    localparam int RB_W    = 16;
    localparam int NUM_LED = 6;

    // LED slots of the override mux
    localparam int LED_GREEN  = 0;
    localparam int LED_RED    = 1;
    localparam int LED_PWR_N  = 2;
    localparam int LED_PWR_P  = 3;
    localparam int LED_DISK_N = 4;
    localparam int LED_DISK_P = 5;

    typedef enum logic [1:0] {
        MB_GAP       = 2'd0,
        MB_PULSE_ON  = 2'd1,
        MB_PULSE_OFF = 2'd2
    } mb_state_e;

    // Remote word bit that overrides each LED slot
    function automatic int ovr_pos(input int slot);
        case (slot)
            LED_GREEN:  return 5;
            LED_RED:    return 6;
            LED_PWR_N:  return 7;
            LED_PWR_P:  return 8;
            LED_DISK_N: return 9;
            default:    return 10;
        endcase
    endfunction

    // Whether the override bit is inverted for a slot
    function automatic bit ovr_inv(input int slot);
        return (slot == LED_PWR_P) || (slot == LED_DISK_P);
    endfunction

endpackage

// File: rtl/blink_divider.sv
module blink_divider #(
    parameter int SLOW_DIV = 17554286,
    parameter int TICK_DIV = 24576
) (
    input  logic clk,
    input  logic rst,
    output logic slow_blink,
    output logic slow_wrap,
    output logic tick
);
    localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [SW-1:0] SLOW_MAX = SW'(SLOW_DIV - 1);
    localparam logic [TW-1:0] TICK_MAX = TW'(TICK_DIV - 1);

    logic [SW-1:0] slow_cnt;
    logic [TW-1:0] tick_cnt;

    assign slow_wrap = (slow_cnt == SLOW_MAX);
    assign tick      = (tick_cnt == TICK_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            slow_cnt   <= '0;
            slow_blink <= 1'b0;
        end else if (slow_wrap) begin
            slow_cnt   <= '0;
            slow_blink <= ~slow_blink;
        end else begin
            slow_cnt   <= slow_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt <= '0;
        end else if (tick) begin
            tick_cnt <= '0;
        end else begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mode_blink_fsm.sv
module mode_blink_fsm
    import sled_pkg::*;
#(
    parameter int GAP_TICKS = 1400,
    parameter int ON_TICKS  = 120,
    parameter int OFF_TICKS = 180,
    parameter int PULSES    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic mode_blink
);
    localparam int MAXT = (GAP_TICKS > ON_TICKS)
                        ? ((GAP_TICKS > OFF_TICKS) ? GAP_TICKS : OFF_TICKS)
                        : ((ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS);
    localparam int CW = (MAXT > 1) ? $clog2(MAXT) : 1;
    localparam int PW = (PULSES > 1) ? $clog2(PULSES) : 1;
    localparam logic [CW-1:0] GAP_LAST = CW'(GAP_TICKS - 1);
    localparam logic [CW-1:0] ON_LAST  = CW'(ON_TICKS - 1);
    localparam logic [CW-1:0] OFF_LAST = CW'(OFF_TICKS - 1);
    localparam logic [PW-1:0] P_LAST   = PW'(PULSES - 1);

    mb_state_e     state, state_nx;
    logic [CW-1:0] ph_cnt, ph_cnt_nx;
    logic [PW-1:0] p_idx, p_idx_nx;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= MB_GAP;
            ph_cnt <= '0;
            p_idx  <= '0;
        end else begin
            state  <= state_nx;
            ph_cnt <= ph_cnt_nx;
            p_idx  <= p_idx_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx  = state;
        ph_cnt_nx = ph_cnt;
        p_idx_nx  = p_idx;
        if (tick) begin
            unique case (state)
                MB_GAP: begin
                    if (ph_cnt == GAP_LAST) begin
                        state_nx  = MB_PULSE_ON;
                        ph_cnt_nx = '0;
                        p_idx_nx  = '0;
                    end else begin
                        ph_cnt_nx = ph_cnt + 1'b1;
                    end
                end
                MB_PULSE_ON: begin
                    if (ph_cnt == ON_LAST) begin
                        state_nx  = MB_PULSE_OFF;
                        ph_cnt_nx = '0;
                    end else begin
                        ph_cnt_nx = ph_cnt + 1'b1;
                    end
                end
                MB_PULSE_OFF: begin
                    if (ph_cnt == OFF_LAST) begin
                        ph_cnt_nx = '0;
                        if (p_idx == P_LAST) begin
                            state_nx = MB_GAP;
                            p_idx_nx = '0;
                        end else begin
                            state_nx = MB_PULSE_ON;
                            p_idx_nx = p_idx + 1'b1;
                        end
                    end else begin
                        ph_cnt_nx = ph_cnt + 1'b1;
                    end
                end
                default: begin
                    state_nx  = MB_GAP;
                    ph_cnt_nx = '0;
                    p_idx_nx  = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            MB_PULSE_ON: mode_blink = 1'b1;
            default:     mode_blink = 1'b0;
        endcase
    end

endmodule

// File: rtl/led_sel.sv
module led_sel #(
    parameter bit INVERT = 1'b0
) (
    input  logic remote_active,
    input  logic ovr_bit,
    input  logic fallback,
    output logic led
);
    always_comb begin
        if (remote_active) begin
            led = INVERT ? ~ovr_bit : ovr_bit;
        end else begin
            led = fallback;
        end
    end
endmodule

// File: rtl/status_led_drv.sv
module status_led_drv
    import sled_pkg::*;
#(
    parameter int SLOW_DIV  = 17554286,
    parameter int TICK_DIV  = 24576,
    parameter int GAP_TICKS = 1400,
    parameter int ON_TICKS  = 120,
    parameter int OFF_TICKS = 180,
    parameter int PULSES    = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            remote_active,
    input  logic [RB_W-1:0] remote_bits,
    input  logic            power_on,
    input  logic            rst_btn_n,
    input  logic            mio_fwd,
    input  logic            fpga_io_fwd,
    input  logic            cfg_done,
    output logic            led_green,
    output logic            led_red,
    output logic            pwr_led_n,
    output logic            pwr_led_p,
    output logic            disk_led_n,
    output logic            disk_led_p,
    output logic            hdr_led
);
    logic slow_blink;
    logic slow_wrap;
    logic mode_tick;
    logic mode_blink;
    logic [NUM_LED-1:0] fb;
    logic [NUM_LED-1:0] led_vec;

    blink_divider #(
        .SLOW_DIV (SLOW_DIV),
        .TICK_DIV (TICK_DIV)
    ) u_div (
        .clk        (clk),
        .rst        (rst),
        .slow_blink (slow_blink),
        .slow_wrap  (slow_wrap),
        .tick       (mode_tick)
    );

    mode_blink_fsm #(
        .GAP_TICKS (GAP_TICKS),
        .ON_TICKS  (ON_TICKS),
        .OFF_TICKS (OFF_TICKS),
        .PULSES    (PULSES)
    ) u_mode (
        .clk        (clk),
        .rst        (rst),
        .tick       (mode_tick),
        .mode_blink (mode_blink)
    );

    // Local fallback per LED slot
    always_comb begin
        fb             = '0;
        fb[LED_GREEN]  = power_on ? 1'b1 : slow_blink;
        fb[LED_RED]    = ~rst_btn_n | mode_blink;
        fb[LED_PWR_N]  = 1'b0;
        fb[LED_PWR_P]  = power_on ? mio_fwd : slow_blink;
        fb[LED_DISK_N] = 1'b0;
        fb[LED_DISK_P] = fpga_io_fwd;
    end

    for (genvar i = 0; i < NUM_LED; i++) begin : g_led
        led_sel #(
            .INVERT (ovr_inv(i))
        ) u_sel (
            .remote_active (remote_active),
            .ovr_bit       (remote_bits[ovr_pos(i)]),
            .fallback      (fb[i]),
            .led           (led_vec[i])
        );
    end

    assign led_green  = led_vec[LED_GREEN];
    assign led_red    = led_vec[LED_RED];
    assign pwr_led_n  = led_vec[LED_PWR_N];
    assign pwr_led_p  = led_vec[LED_PWR_P];
    assign disk_led_n = led_vec[LED_DISK_N];
    assign disk_led_p = led_vec[LED_DISK_P];
    assign hdr_led    = ~cfg_done;

endmodule

// File: rtl/status_led_chk.sv
module status_led_chk
    import sled_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            remote_active,
    input logic [RB_W-1:0] remote_bits,
    input logic            power_on,
    input logic            cfg_done,
    input logic            led_green,
    input logic            pwr_led_n,
    input logic            pwr_led_p,
    input logic            disk_led_n,
    input logic            hdr_led,
    input logic            slow_blink,
    input logic            slow_wrap,
    input logic            mode_tick,
    input logic            mode_blink
);
    // R1
    slow_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (slow_blink != $past(slow_blink)) |-> $past(slow_wrap));

    // R8
    mode_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_blink) |-> $past(mode_tick));

    // R2
    green_ovr_chk: assert property (@(posedge clk) disable iff (rst)
        remote_active |-> (led_green == remote_bits[5]));

    // R4
    neg_off_chk: assert property (@(posedge clk) disable iff (rst)
        !remote_active |-> (!pwr_led_n && !disk_led_n));

    // R5
    pwr_blink_chk: assert property (@(posedge clk) disable iff (rst)
        (!remote_active && !power_on) |-> (pwr_led_p == slow_blink));

    // R7
    hdr_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        hdr_led != cfg_done);
endmodule

bind status_led_drv status_led_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .remote_active (remote_active),
    .remote_bits   (remote_bits),
    .power_on      (power_on),
    .cfg_done      (cfg_done),
    .led_green     (led_green),
    .pwr_led_n     (pwr_led_n),
    .pwr_led_p     (pwr_led_p),
    .disk_led_n    (disk_led_n),
    .hdr_led       (hdr_led),
    .slow_blink    (slow_blink),
    .slow_wrap     (slow_wrap),
    .mode_tick     (mode_tick),
    .mode_blink    (mode_blink)
);

// File: tb/status_led_drv_tb.sv
`timescale 1ns/1ps
module status_led_drv_tb;
    localparam int SLOW_DIV = 40;
    localparam int TICK_DIV = 3;
    localparam int GAP_T    = 5;
    localparam int ON_T     = 2;
    localparam int OFF_T    = 1;
    localparam int NPULSE   = 3;
    localparam int PERIOD_T = GAP_T + NPULSE * (ON_T + OFF_T);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ra = 1'b0;
    logic [15:0] rb = '0;
    logic        pwr = 1'b0;
    logic        btn_n = 1'b1;
    logic        mio = 1'b0;
    logic        fio = 1'b0;
    logic        done = 1'b0;
    logic        g, r, pn, pp, dn, dp, h;

    int n_edges = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) n_edges <= 0;
        else     n_edges <= n_edges + 1;
    end

    status_led_drv #(
        .SLOW_DIV (SLOW_DIV), .TICK_DIV (TICK_DIV),
        .GAP_TICKS(GAP_T), .ON_TICKS(ON_T), .OFF_TICKS(OFF_T), .PULSES(NPULSE)
    ) u_dut (
        .clk(clk), .rst(rst), .remote_active(ra), .remote_bits(rb),
        .power_on(pwr), .rst_btn_n(btn_n), .mio_fwd(mio), .fpga_io_fwd(fio),
        .cfg_done(done), .led_green(g), .led_red(r), .pwr_led_n(pn),
        .pwr_led_p(pp), .disk_led_n(dn), .disk_led_p(dp), .hdr_led(h)
    );

    function automatic logic exp_slow(input int n);
        return logic'((n / SLOW_DIV) % 2);
    endfunction

    function automatic logic exp_mode(input int n);
        int m;
        m = (n / TICK_DIV) % PERIOD_T;
        if (m < GAP_T) return 1'b0;
        return logic'(((m - GAP_T) % (ON_T + OFF_T)) < ON_T);
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (edges %0d)", tag, act, exp, n_edges);
        end
    endtask

    // All outputs against the bench model; n = edges since reset release
    task automatic check_all(input int n);
        logic sb, mb;
        sb = rst ? 1'b0 : exp_slow(n);
        mb = rst ? 1'b0 : exp_mode(n);
        chk("R2 led_green",  g,  ra ? rb[5]   : (pwr ? 1'b1 : sb));
        chk("R3 led_red",    r,  ra ? rb[6]   : (~btn_n | mb));
        chk("R4 pwr_led_n",  pn, ra ? rb[7]   : 1'b0);
        chk("R5 pwr_led_p",  pp, ra ? ~rb[8]  : (pwr ? mio : sb));
        chk("R4 disk_led_n", dn, ra ? rb[9]   : 1'b0);
        chk("R6 disk_led_p", dp, ra ? ~rb[10] : fio);
        chk("R7 hdr_led",    h,  ~done);
    endtask

    task automatic step_check();
        @(negedge clk);
        #1;
        check_all(n_edges);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // Reset state
        repeat (4) @(negedge clk);
        #1;
        chk("R9 reset green dark", g, 1'b0);
        chk("R9 reset red dark", r, 1'b0);
        chk("R7 reset hdr on", h, 1'b1);
        @(negedge clk);
        rst = 1'b0;

        // Slow blink and burst pattern, link inactive, power off (R1, R8)
        for (int i = 0; i < 200; i++) begin
            step_check();
            chk("R1 slow blink", g, exp_slow(n_edges));
            chk("R8 burst", r, exp_mode(n_edges));
        end

        // Directed remote words
        @(negedge clk);
        ra = 1'b1; rb = 16'h0000;
        #1; check_all(n_edges);
        chk("R5 inverted bit low", pp, 1'b1);
        chk("R6 inverted bit low", dp, 1'b1);
        @(negedge clk);
        rb = 16'hFFFF; done = 1'b1;
        #1; check_all(n_edges);
        chk("R4 neg legs high", pn & dn, 1'b1);
        chk("R7 ignores override", h, 1'b0);
        @(negedge clk);
        rb = 16'h0020;
        #1; check_all(n_edges);
        chk("R2 single bit", g, 1'b1);
        chk("R3 neighbour bit", r, 1'b0);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            ra    = ($urandom_range(0, 9) < 3);
            rb    = 16'($urandom);
            pwr   = $urandom_range(0, 1) == 1;
            btn_n = ($urandom_range(0, 9) != 0);
            mio   = $urandom_range(0, 1) == 1;
            fio   = $urandom_range(0, 1) == 1;
            done  = $urandom_range(0, 1) == 1;
            #1; check_all(n_edges);
        end

        // Mid-run reset restarts both generators (R9)
        @(negedge clk);
        ra = 1'b0; pwr = 1'b0; btn_n = 1'b1;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R9 slow restarted", g, 1'b0);
        chk("R9 burst restarted", r, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 120; i++) begin
            step_check();
            chk("R9 phase after reset", g, exp_slow(n_edges));
            chk("R8 burst after reset", r, exp_mode(n_edges));
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule